// File: doc/BRIEF.md
# Serial Sample Readout Shift Register

This block hands a converter result to the outside world one bit at a time over a single data line. A parallel word from the conversion output register feeds a shift register. Software or a host device controls it with two inputs: an active-low load level and a shift clock.

While the load input is held low, the register follows the parallel word on every system clock. The shift clock has no effect during that time. Once load is released high, each rising edge of the shift clock moves the register up by one place. The serial output therefore presents the most significant bit first and works down to bit 0. Zeros enter at the low end, so any shifts beyond the word width produce a steady stream of zeros until the next load.

Both control inputs are sampled in the single system-clock domain, and the shift clock passes through a rising-edge detector. The serial output is taken from a register bit, so it is free of glitches.

Top module: `ssr_readout`

## Requirements
- R1: After reset the shift register holds all zeros and the serial output is 0, and shift-clock edges with load high keep it at 0.
- R2: On every system-clock edge at which load_n is sampled low, the register takes the current parallel word. This is level-sensitive: a change of the word while load_n stays low is picked up. The serial output shows bit W-1 (the MSB) from that edge on.
- R3: A shift-clock rising edge that arrives while load_n is low does not shift the register. The load takes priority and the serial output keeps the MSB of the word.
- R4: With load_n high, each detected rising edge of the shift clock shifts the register one place toward the MSB. After k shifts the serial output shows bit W-1-k of the loaded word.
- R5: With load_n high, no shift happens without a rising edge. Shift clock held high or held low leaves the output unchanged. A shift clock that is already high when load_n is released does not shift.
- R6: A zero enters bit 0 on each shift. After W or more shifts without a load, the serial output is 0 and stays 0 until load_n goes low again.
- R7: A rising edge is recognised when the shift clock is sampled low at one system-clock edge and high at the next. Each shift-clock level must therefore last at least one system-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low level load; low copies par_word into the register |
| sclk | input | 1 | Shift clock, sampled by clk; a rising edge shifts one place |
| par_word | input | W (12) | Parallel conversion result to be serialised |
| sdo | output | 1 | Serial data out, MSB of the shift register |

## Verification
Every result of this block appears one system-clock edge after the stimulus that causes it. A load sampled low shows its MSB after the next clk edge, and a shift-clock rise driven before an edge shows the next bit right after that edge. The bench drives all inputs on the falling edge of clk and reads sdo on the following falling edge, which is exactly half a period after the edge that updated it. Held-level and early-high cases for the shift clock are each checked over several edges to show that no extra shift occurs.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } ssr_op_e;

endpackage

// File: rtl/ssr_edge_det.sv
module ssr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic level_q,
    output logic rise
);

    typedef struct packed {
        logic level;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = sig_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_q = st_q.level;
    assign rise    = sig_in & ~st_q.level;

endmodule

// File: rtl/ssr_ctrl.sv
module ssr_ctrl
    import ssr_pkg::*;
(
    input  logic    load_n,
    input  logic    sclk_rise,
    output ssr_op_e op
);

    always_comb begin
        if (!load_n)        op = OP_LOAD;
        else if (sclk_rise) op = OP_SHIFT;
        else                op = OP_HOLD;
    end

endmodule

// File: rtl/ssr_shifter.sv
module ssr_shifter
    import ssr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ssr_op_e      op,
    input  logic [W-1:0] par,
    output logic [W-1:0] word_q
);

    localparam int TOP = W - 1;

    typedef struct packed {
        logic [TOP:0] word;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (op)
            OP_LOAD:  st_d.word = par;
            OP_SHIFT: st_d.word = {st_q.word[TOP-1:0], 1'b0};
            default:  st_d.word = st_q.word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_q = st_q.word;

endmodule

// File: rtl/ssr_readout.sv
module ssr_readout
    import ssr_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         sclk,
    input  logic [W-1:0] par_word,
    output logic         sdo
);

    logic         sclk_prev;
    logic         sclk_rise;
    ssr_op_e      op;
    logic [W-1:0] word_q;

    ssr_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (sclk),
        .level_q (sclk_prev),
        .rise    (sclk_rise)
    );

    ssr_ctrl u_ctrl (
        .load_n    (load_n),
        .sclk_rise (sclk_rise),
        .op        (op)
    );

    ssr_shifter #(.W(W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par    (par_word),
        .word_q (word_q)
    );

    assign sdo = word_q[W-1];

endmodule

// File: rtl/ssr_readout_chk.sv
module ssr_readout_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_n,
    input logic         sclk,
    input logic [W-1:0] par_word,
    input logic         sdo,
    input logic [W-1:0] word_q,
    input logic         sclk_prev
);

    // R1: reset leaves the register empty
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (word_q == '0));

    // R2: a low load level captures the parallel word and shows its MSB
    a_r2_level_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (sdo == $past(par_word[W-1])));

    // R3 / R4: a detected rise with load high shifts with zero fill
    a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && sclk && !sclk_prev) |=> (word_q == {$past(word_q[W-2:0]), 1'b0}));

    // R5: no rise, no change
    a_r5_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !(sclk && !sclk_prev)) |=> $stable(word_q));

    // R6: an emptied register stays empty until a load
    a_r6_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && word_q == '0) |=> (word_q == '0));

    // R7: the sampled shift-clock level follows the input one edge later
    a_r7_sample: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (sclk_prev == $past(sclk)));

endmodule

bind ssr_readout ssr_readout_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_n    (load_n),
    .sclk      (sclk),
    .par_word  (par_word),
    .sdo       (sdo),
    .word_q    (word_q),
    .sclk_prev (sclk_prev)
);

// File: tb/ssr_readout_tb.sv
module ssr_readout_tb;

    localparam int W = 12;
    localparam int NV = 6;
    localparam logic [W-1:0] VEC [NV] = '{12'hA5C, 12'hFFF, 12'h000,
                                          12'h800, 12'h001, 12'h5A3};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] par_word = '0;
    logic         sdo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ssr_readout #(.W(W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .sclk     (sclk),
        .par_word (par_word),
        .sdo      (sdo)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sdo got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic do_load(input logic [W-1:0] w);
        @(negedge clk);
        load_n   = 1'b0;
        par_word = w;
        @(negedge clk);
    endtask

    task automatic release_load();
        load_n = 1'b1;
        @(negedge clk);
    endtask

    // one shift-clock pulse; returns sdo after the rise has been seen
    task automatic pulse(output logic seen);
        sclk = 1'b1;
        @(negedge clk);
        seen = sdo;
        sclk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic b;
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        chk("R1 reset", sdo, 1'b0);
        rst_n = 1'b1;
        par_word = 12'hFFF;
        @(negedge clk);
        chk("R1 after release", sdo, 1'b0);
        pulse(b);
        chk("R1 shift from empty", b, 1'b0);

        // vector table walk: R2, R4, R6
        for (int v = 0; v < NV; v++) begin
            w = VEC[v];
            do_load(w);
            chk("R2 msb on load", sdo, w[W-1]);
            release_load();
            chk("R2 msb after release", sdo, w[W-1]);
            for (int k = 1; k <= W + 2; k++) begin
                pulse(b);
                if (k < W) chk("R4 shift bit", b, w[W-1-k]);
                else       chk("R6 zero fill", b, 1'b0);
            end
        end

        // R2 level sensitivity: change the word while load stays low
        do_load(12'h000);
        chk("R2 level low word", sdo, 1'b0);
        par_word = 12'h800;
        @(negedge clk);
        chk("R2 level tracks word", sdo, 1'b1);

        // R3: shift-clock pulses during load are ignored
        pulse(b);
        chk("R3 rise ignored during load", b, 1'b1);
        pulse(b);
        chk("R3 second rise ignored", b, 1'b1);
        release_load();
        chk("R3 msb kept", sdo, 1'b1);
        pulse(b);
        chk("R3 first shift bit10", b, 1'b0);

        // R5: sclk already high at release gives no shift
        do_load(12'hC00);
        sclk = 1'b1;
        @(negedge clk);
        release_load();
        repeat (3) @(negedge clk);
        chk("R5 high at release no shift", sdo, 1'b1);
        sclk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 held low no shift", sdo, 1'b1);
        pulse(b);
        chk("R5 rise shifts bit10", b, 1'b1);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        chk("R5 held high one shift only", sdo, 1'b0);
        sclk = 1'b0;
        @(negedge clk);

        // R7: one-cycle high, one-cycle low pulses each shift once
        do_load(12'hAAA);
        release_load();
        for (int k = 1; k < W; k++) begin
            pulse(b);
            chk("R7 minimum pulse shift", b, k[0] ? 1'b0 : 1'b1);
        end

        // R6: stays zero until next load, then reload works
        for (int k = 0; k < 3; k++) pulse(b);
        repeat (5) @(negedge clk);
        chk("R6 stays zero", sdo, 1'b0);
        do_load(12'h800);
        chk("R6 reload after empty", sdo, 1'b1);
        release_load();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule